// File: doc/BRIEF.md
# Bipolar-Pulse Serial Link Transmitter

This block turns packets held in a 32-bit word FIFO into a stream of framed bytes on a half-duplex twisted-pair line that is driven through an 8-bit DAC. The line code is DC-free. A one bit is a rectangular pulse that sits at a high DAC code for the first half of the bit time and at a low DAC code for the second half. A zero bit leaves the line at the mid-scale quiet code. Each byte travels in a UART-like frame. The frame carries a tag bit that marks the byte as data or control. A control byte packs a 2-bit slave address, a 4-bit command and an odd parity bit.

A packet starts with a header word at the head of the FIFO. The header gives the payload length in bytes in bits 15:0 and the packet type in bits 23:16; bits 31:24 are free for software. The packet sequencer sends, in this order: a start-of-frame control byte, a packet sequence number, the four header bytes, the payload bytes, and an end-of-frame control byte. The sequence number is a running count that lets the receiver spot lost packets. The bit time is `BIT_CYCLES` clocks. With the default of 20 clocks and a 20 MHz clock, the line runs at 1 Mbit/s.

There are two state machines. The packet sequencer uses the states IDLE, SOF, SEQ, HDR, LOAD, PAY and EOF, with these transitions:
- IDLE→SOF: a header is popped.
- SOF→SEQ: the start byte is handed over.
- SEQ→HDR: the sequence byte is handed over.
- HDR→LOAD or HDR→EOF: the fourth header byte goes out; the choice depends on whether payload remains.
- LOAD→PAY: a payload word is popped.
- PAY→LOAD or PAY→EOF: a word is used up, or the last byte is sent.
- EOF→IDLE: the end byte is handed over.

The byte serializer uses the states IDLE and BIT. It goes IDLE→BIT on a hand-over and BIT→IDLE after the last clock of the stop bit.

Top module: `bipolar_link_tx`

## Requirements
- R1: After reset, `dac_code` is 0x80, `busy` is 0 and `fifo_rd` is 0.
- R2: While the FIFO is empty and no packet is in progress, `fifo_rd` stays 0 and `dac_code` stays 0x80.
- R3: A one bit drives `dac_code` to `DAC_HIGH` (0xC0 by default) for the first `BIT_CYCLES/2` clocks of the bit and to `DAC_LOW` (0x40) for the rest. A zero bit holds 0x80 for all `BIT_CYCLES` clocks.
- R4: A frame is 11 consecutive bits: a start bit of value 1, the eight byte bits least significant first, a tag bit (1 = control, 0 = data), and a stop bit of value 1.
- R5: A control byte has the address in bits 1:0, the command in bits 5:2, a parity bit in bit 6 that makes the count of ones in bits 6:0 odd, and 0 in bit 7. The start command is `CMD_SOF` (1) and the end command is `CMD_EOF` (2). The address is `slave_addr` as sampled when the header is popped.
- R6: A packet goes out as: start control byte, sequence data byte, header bytes from bits 7:0 up to bits 31:24, payload data bytes, end control byte.
- R7: Payload bytes come from the words that follow the header, bits 7:0 of each word first. Exactly ceil(length/4) words are popped. Unused bytes of the last word are discarded. `fifo_rd` is never high in two consecutive cycles.
- R8: Only header bits 15:0 steer the hardware. The type and user bits are sent unchanged and do not alter the byte count.
- R9: The sequence byte is 0 for the first packet after reset and rises by one per packet, wrapping from 255 to 0.
- R10: `fifo_rd` is only high while `fifo_empty` is low. A pop takes the word shown on `fifo_data` on that clock edge.
- R11: `busy` is high from the cycle after the header pop until the end byte's stop bit has finished. It stays high while the block waits for a late payload word. It is high whenever `dac_code` is not 0x80.
- R12: A header with length 0 sends no payload bytes, pops no payload word, and goes straight from the header to the end byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | 32 | Word at the head of the FIFO |
| fifo_rd | output | 1 | Pop the head word on this clock edge |
| slave_addr | input | 2 | Address placed in the control bytes of the next packet |
| dac_code | output | 8 | Line DAC code |
| busy | output | 1 | Packet in progress |

## Verification
The checks assume the FIFO behaves in a fixed way. It shows its head word on `fifo_data` whenever `fifo_empty` is low, and it drops that word on a clock edge where `fifo_rd` is high. The checks also assume that `slave_addr` is stable from the header pop to the end of the packet. The bench's FIFO model meets these assumptions. It updates `fifo_empty` and `fifo_data` just after each rising edge, it pops only the pops seen before that edge, and it changes the address only while `busy` is low. One scenario holds back the payload words to exercise the wait in LOAD. Another places a zero-length header directly before a second packet, to show that no extra word is read.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;
    localparam int SEQ_W  = 8;
    localparam int LANES  = WORD_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam logic [7:0] DAC_QUIET = 8'h80;

    typedef enum logic [2:0] {
        P_IDLE, P_SOF, P_SEQ, P_HDR, P_LOAD, P_PAY, P_EOF
    } pkt_state_t;

    typedef enum logic {
        S_IDLE, S_BIT
    } ser_state_t;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] value;
    } line_byte_t;

    function automatic logic [7:0] make_ctrl(input logic [1:0] addr,
                                             input logic [3:0] cmd);
        logic even;
        even = ~^{cmd, addr};
        return {1'b0, even, cmd, addr};
    endfunction

endpackage

// File: rtl/ltx_pulse_shaper.sv
module ltx_pulse_shaper
    import ltx_pkg::*;
#(
    parameter logic [7:0] DAC_HIGH = 8'hC0,
    parameter logic [7:0] DAC_LOW  = 8'h40
) (
    input  logic       line_bit,
    input  logic       first_half,
    output logic [7:0] dac_code
);

    always_comb begin
        if (!line_bit)
            dac_code = DAC_QUIET;
        else if (first_half)
            dac_code = DAC_HIGH;
        else
            dac_code = DAC_LOW;
    end

endmodule

// File: rtl/ltx_byte_serializer.sv
module ltx_byte_serializer
    import ltx_pkg::*;
#(
    parameter int BIT_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       send,
    input  line_byte_t in_byte,
    output logic       ready,
    output logic       line_bit,
    output logic       first_half
);

    localparam int FRAME_BITS = 11;
    localparam int HALF       = BIT_CYCLES / 2;
    localparam int CNT_W      = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(BIT_CYCLES - 1);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

    ser_state_t            state_q, state_d;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [IDX_W-1:0]      idx_q;
    logic [CNT_W-1:0]      cyc_q;
    logic                  bit_end;

    assign bit_end = (cyc_q == LAST_CYC);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (send) state_d = S_BIT;
            S_BIT:   if (bit_end && idx_q == LAST_BIT) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
            cyc_q   <= '0;
        end else if (state_q == S_IDLE) begin
            if (send) begin
                shreg_q <= {1'b1, in_byte.ctrl, in_byte.value, 1'b1};
                idx_q   <= '0;
                cyc_q   <= '0;
            end
        end else if (bit_end) begin
            cyc_q   <= '0;
            idx_q   <= idx_q + 1'b1;
            shreg_q <= {1'b0, shreg_q[FRAME_BITS-1:1]};
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    always_comb begin
        ready      = (state_q == S_IDLE);
        line_bit   = (state_q == S_BIT) && shreg_q[0];
        first_half = (cyc_q < CNT_W'(HALF));
    end

endmodule

// File: rtl/ltx_packet_sequencer.sv
module ltx_packet_sequencer
    import ltx_pkg::*;
#(
    parameter logic [3:0] CMD_SOF = 4'h1,
    parameter logic [3:0] CMD_EOF = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_rd,
    input  logic [1:0]        slave_addr,
    input  logic              ser_ready,
    output logic              send,
    output line_byte_t        out_byte,
    output logic              active
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    pkt_state_t        state_q, state_d;
    logic [WORD_W-1:0] hdr_q, word_q;
    logic [LEN_W-1:0]  left_q;
    logic [LANE_W-1:0] lane_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [1:0]        addr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE: if (!fifo_empty) state_d = P_SOF;
            P_SOF:  if (ser_ready) state_d = P_SEQ;
            P_SEQ:  if (ser_ready) state_d = P_HDR;
            P_HDR:  if (ser_ready && lane_q == LAST_LANE)
                        state_d = (left_q == '0) ? P_EOF : P_LOAD;
            P_LOAD: if (!fifo_empty) state_d = P_PAY;
            P_PAY:  if (ser_ready) begin
                        if (left_q == LEN_W'(1))     state_d = P_EOF;
                        else if (lane_q == LAST_LANE) state_d = P_LOAD;
                    end
            P_EOF:  if (ser_ready) state_d = P_IDLE;
            default: state_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q  <= '0;
            word_q <= '0;
            left_q <= '0;
            lane_q <= '0;
            seq_q  <= '0;
            addr_q <= '0;
        end else begin
            if (state_q == P_IDLE && !fifo_empty) begin
                hdr_q  <= fifo_data;
                left_q <= fifo_data[LEN_W-1:0];
                addr_q <= slave_addr;
            end
            if (state_q == P_LOAD && !fifo_empty)
                word_q <= fifo_data;
            if (state_q == P_SEQ && ser_ready)
                lane_q <= '0;
            if (state_q == P_HDR && ser_ready)
                lane_q <= lane_q + 1'b1;
            if (state_q == P_PAY && ser_ready) begin
                lane_q <= lane_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
            if (state_q == P_EOF && ser_ready)
                seq_q <= seq_q + 1'b1;
        end
    end

    always_comb begin
        out_byte = '0;
        send     = 1'b0;
        fifo_rd  = 1'b0;
        unique case (state_q)
            P_IDLE: fifo_rd = !fifo_empty;
            P_SOF: begin
                send     = ser_ready;
                out_byte = '{ctrl: 1'b1, value: make_ctrl(addr_q, CMD_SOF)};
            end
            P_SEQ: begin
                send     = ser_ready;
                out_byte = '{ctrl: 1'b0, value: 8'(seq_q)};
            end
            P_HDR: begin
                send     = ser_ready;
                out_byte = '{ctrl: 1'b0, value: hdr_q[{lane_q, 3'b000} +: 8]};
            end
            P_LOAD: fifo_rd = !fifo_empty;
            P_PAY: begin
                send     = ser_ready;
                out_byte = '{ctrl: 1'b0, value: word_q[{lane_q, 3'b000} +: 8]};
            end
            P_EOF: begin
                send     = ser_ready;
                out_byte = '{ctrl: 1'b1, value: make_ctrl(addr_q, CMD_EOF)};
            end
            default: ;
        endcase
        active = (state_q != P_IDLE);
    end

endmodule

// File: rtl/bipolar_link_tx.sv
module bipolar_link_tx
    import ltx_pkg::*;
#(
    parameter int         BIT_CYCLES = 20,
    parameter logic [7:0] DAC_HIGH   = 8'hC0,
    parameter logic [7:0] DAC_LOW    = 8'h40,
    parameter logic [3:0] CMD_SOF    = 4'h1,
    parameter logic [3:0] CMD_EOF    = 4'h2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_empty,
    input  logic [31:0] fifo_data,
    output logic        fifo_rd,
    input  logic [1:0]  slave_addr,
    output logic [7:0]  dac_code,
    output logic        busy
);

    logic       ser_ready, send, line_bit, first_half, seq_active;
    line_byte_t next_byte;

    ltx_packet_sequencer #(
        .CMD_SOF(CMD_SOF),
        .CMD_EOF(CMD_EOF)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_rd    (fifo_rd),
        .slave_addr (slave_addr),
        .ser_ready  (ser_ready),
        .send       (send),
        .out_byte   (next_byte),
        .active     (seq_active)
    );

    ltx_byte_serializer #(
        .BIT_CYCLES(BIT_CYCLES)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .send       (send),
        .in_byte    (next_byte),
        .ready      (ser_ready),
        .line_bit   (line_bit),
        .first_half (first_half)
    );

    ltx_pulse_shaper #(
        .DAC_HIGH(DAC_HIGH),
        .DAC_LOW (DAC_LOW)
    ) u_shape (
        .line_bit   (line_bit),
        .first_half (first_half),
        .dac_code   (dac_code)
    );

    assign busy = seq_active || !ser_ready;

endmodule

// File: rtl/bipolar_link_tx_chk.sv
module bipolar_link_tx_chk
    import ltx_pkg::*;
#(
    parameter logic [7:0] DAC_HIGH = 8'hC0,
    parameter logic [7:0] DAC_LOW  = 8'h40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_empty,
    input logic       fifo_rd,
    input logic [7:0] dac_code,
    input logic       busy
);

    a_r10_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    a_r7_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> !fifo_rd);

    a_r11_busy_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code != DAC_QUIET) |-> busy);

    a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code == DAC_QUIET) || (dac_code == DAC_HIGH) || (dac_code == DAC_LOW));

    a_r3_high_falls_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dac_code) == DAC_HIGH && dac_code != DAC_HIGH) |-> dac_code == DAC_LOW);

    a_r3_low_follows_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code == DAC_LOW && $past(dac_code) != DAC_LOW) |-> $past(dac_code) == DAC_HIGH);

endmodule

bind bipolar_link_tx bipolar_link_tx_chk #(
    .DAC_HIGH(DAC_HIGH),
    .DAC_LOW (DAC_LOW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .dac_code   (dac_code),
    .busy       (busy)
);

// File: tb/test_bipolar_link_tx.sv
module test_bipolar_link_tx;

    localparam int CLK_PERIOD = 10;
    localparam int BITC       = 4;
    localparam int HALF       = BITC / 2;
    localparam logic [7:0] HI = 8'hC0;
    localparam logic [7:0] LO = 8'h40;
    localparam logic [7:0] QT = 8'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_data = '0;
    logic        fifo_rd;
    logic [1:0]  slave_addr = 2'd0;
    logic [7:0]  dac_code;
    logic        busy;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_seq = 8'd0;

    logic [31:0] fq[$];
    logic [8:0]  rx_q[$];
    logic [8:0]  exp_q[$];
    string       exp_req[$];
    logic [31:0] pend[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bipolar_link_tx #(.BIT_CYCLES(BITC)) i_bipolar_link_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_rd    (fifo_rd),
        .slave_addr (slave_addr),
        .dac_code   (dac_code),
        .busy       (busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // FIFO model: pops seen before an edge take effect just after it
    initial begin
        bit rd_seen;
        forever begin
            @(negedge clk);
            rd_seen = fifo_rd;
            @(posedge clk);
            #1;
            if (rd_seen && fq.size() > 0) void'(fq.pop_front());
            fifo_empty = (fq.size() == 0);
            fifo_data  = (fq.size() == 0) ? 32'h0 : fq[0];
        end
    end

    // Line decoder: rebuilds frames from the DAC codes
    initial begin
        logic [10:0] bits;
        logic [7:0]  a, b;
        forever begin
            @(negedge clk);
            if (rst_n && dac_code != QT) begin
                for (int k = 0; k < 11; k++) begin
                    if (k > 0) repeat (BITC - HALF) @(negedge clk);
                    a = dac_code;
                    repeat (HALF) @(negedge clk);
                    b = dac_code;
                    if (a == HI && b == LO)      bits[k] = 1'b1;
                    else if (a == QT && b == QT) bits[k] = 1'b0;
                    else begin
                        bits[k] = 1'b0;
                        chk(1'b0, "R3", "bit shape", {a, b}, 32'h0);
                    end
                end
                chk(bits[0] == 1'b1, "R4", "start bit", bits[0], 1);
                chk(bits[10] == 1'b1, "R4", "stop bit", bits[10], 1);
                rx_q.push_back({bits[9], bits[8:1]});
                repeat (BITC - HALF - 1) @(negedge clk);
            end
        end
    end

    function automatic logic [7:0] ctrl_exp(input logic [1:0] addr, input logic [3:0] cmd);
        logic p;
        p = ($countones({cmd, addr}) % 2) == 0;
        return {1'b0, p, cmd, addr};
    endfunction

    // Appends one packet to pend (FIFO words) and exp_q (line bytes)
    task automatic plan_packet(input int len, input logic [7:0] ptype,
                               input logic [7:0] user, input logic [1:0] addr,
                               input logic [7:0] seed);
        logic [31:0] hdr, w;
        int nwords;
        hdr = {user, ptype, 16'(len)};
        pend.push_back(hdr);
        exp_q.push_back({1'b1, ctrl_exp(addr, 4'h1)}); exp_req.push_back("R5 start byte");
        exp_q.push_back({1'b0, exp_seq});               exp_req.push_back("R9 sequence");
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back({1'b0, hdr[8*i +: 8]});     exp_req.push_back("R8 header");
        end
        nwords = (len + 3) / 4;
        for (int wi = 0; wi < nwords; wi++) begin
            for (int bi = 0; bi < 4; bi++) begin
                if (4*wi + bi < len) begin
                    w[8*bi +: 8] = seed + 8'(13 * (4*wi + bi));
                    exp_q.push_back({1'b0, w[8*bi +: 8]}); exp_req.push_back("R7 payload");
                end else begin
                    w[8*bi +: 8] = 8'hEE;
                end
            end
            pend.push_back(w);
        end
        exp_q.push_back({1'b1, ctrl_exp(addr, 4'h2)}); exp_req.push_back("R5 end byte");
        exp_seq++;
    endtask

    task automatic wait_frames(input int n);
        int t = 0;
        while (rx_q.size() < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic compare_all();
        chk(rx_q.size() == exp_q.size(), "R6", "frame count", rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
            chk(rx_q[i] == exp_q[i], "R6", exp_req[i], rx_q[i], exp_q[i]);
        chk(busy == 1'b0, "R11", "busy after end", busy, 0);
        chk(fq.size() == 0, "R7", "words left in fifo", fq.size(), 0);
        rx_q.delete(); exp_q.delete(); exp_req.delete();
    endtask

    task automatic push_pend();
        while (pend.size() > 0) fq.push_back(pend.pop_front());
    endtask

    task automatic t_reset();
        chk(dac_code == QT, "R1", "reset dac", dac_code, QT);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(fifo_rd == 1'b0, "R1", "reset rd", fifo_rd, 0);
    endtask

    task automatic t_idle();
        bit rd_seen = 0, line_seen = 0;
        repeat (30) begin
            @(negedge clk);
            if (fifo_rd) rd_seen = 1;
            if (dac_code != QT) line_seen = 1;
        end
        chk(!rd_seen, "R2", "pop on empty", rd_seen, 0);
        chk(!line_seen, "R2", "line activity idle", line_seen, 0);
    endtask

    task automatic t_packet(input int len, input logic [7:0] ptype,
                            input logic [7:0] user, input logic [1:0] addr);
        slave_addr = addr;
        plan_packet(len, ptype, user, addr, 8'h30 + 8'(len));
        push_pend();
        wait_frames(exp_q.size());
        compare_all();
    endtask

    task automatic t_starve();
        logic [31:0] hold[$];
        bit high_seen = 0;
        slave_addr = 2'd1;
        plan_packet(3, 8'h07, 8'h00, 2'd1, 8'h90);
        fq.push_back(pend.pop_front());
        hold = pend; pend.delete();
        repeat (400) @(negedge clk);
        chk(rx_q.size() == 6, "R11", "frames before stall", rx_q.size(), 6);
        chk(busy == 1'b1, "R11", "busy during stall", busy, 1);
        chk(dac_code == QT, "R11", "quiet during stall", dac_code, QT);
        foreach (hold[i]) fq.push_back(hold[i]);
        @(negedge clk);
        if (busy) high_seen = 1;
        chk(high_seen, "R11", "busy after resume", high_seen, 1);
        wait_frames(exp_q.size());
        compare_all();
    endtask

    task automatic t_zero_then_next();
        slave_addr = 2'd2;
        plan_packet(0, 8'h11, 8'h22, 2'd2, 8'h00);
        plan_packet(5, 8'h33, 8'h44, 2'd2, 8'h50);
        push_pend();
        wait_frames(exp_q.size());
        // R12: zero-length packet pops no payload word, so the next header is intact
        chk(exp_q.size() == 19, "R12", "planned frames", exp_q.size(), 19);
        compare_all();
    endtask

    task automatic t_wrap();
        int n = 257 - int'(exp_seq);
        slave_addr = 2'd0;
        repeat (n) begin
            plan_packet(0, 8'h00, 8'h00, 2'd0, 8'h00);
            push_pend();
            wait_frames(exp_q.size());
            compare_all();
        end
        chk(exp_seq == 8'd1, "R9", "wrap reached", exp_seq, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", "timeout", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_packet(7, 8'h5A, 8'hC3, 2'd3);
        t_packet(8, 8'h01, 8'hFF, 2'd0);
        t_packet(1, 8'hA5, 8'h7E, 2'd2);
        t_starve();
        t_zero_then_next();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule